// File: doc/BRIEF.md
# SCL Prescaler Timing Generator

This block produces the serial clock for a two-wire bus controller from a fast source clock. Three counters are chained. A front divider thins the source clock into prescaled ticks. A sample counter turns those into sample ticks. A step counter counts sample ticks for each half of the SCL period. As a result, each half period lasts `div × sample × step` source cycles, and the bus frequency is the source rate divided by twice that product.

Two timing words are provided. One serves ordinary speeds. The other serves the high-speed mode and has a narrower step field. Every field holds its count minus one. A separate word places the point inside SCL low where the sequencer may change the data line, counted in sample units.

The block drives three outputs for the protocol sequencer: the SCL level, a one-clock strobe at each SCL transition, and a one-clock data-change strobe. The whole timing set is captured at the start of each low phase. A write in the middle of a phase therefore never shortens or stretches the phase already under way.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is held, and while `en` stays low after reset, `scl` is 1 and both `scl_edge` and `data_stb` are 0.
- R2: When `en` is sampled high while the generator is idle, `scl` is 0 from the next clock edge on, and `scl_edge` is 1 in that same cycle.
- R3: In normal mode, `nrm_word[10:8]` holds sample−1 and `nrm_word[5:0]` holds step−1. Each low half and each high half of SCL lasts div × sample × step clock cycles.
- R4: `div_word[7:0]` holds div−1, which gives a front division from 1 to 256 that applies to both modes.
- R5: High-speed timing is used only when `hs_sel` is 1 and `hs_word[1:0]` equals 3. In that case `hs_word[14:12]` holds sample−1 and `hs_word[10:8]` holds step−1, so step ranges over 1..8. In every other case, including an all-zero `hs_word`, the normal word applies.
- R6: `scl_edge` is 1 for exactly one clock in each cycle where `scl` differs from its value in the previous cycle, and is 0 otherwise.
- R7: `sda_word[12]` enables placement and `sda_word[5:0]` gives the offset K. `data_stb` pulses once per low phase, K × div × sample cycles after the cycle in which `scl` fell. When placement is disabled, K is taken as 0, so the pulse coincides with the fall.
- R8: A placement offset K larger than step−1 is clamped to step−1, which keeps the data strobe inside the low phase.
- R9: Changes to any timing input take effect only at the next start of an SCL low phase. The phase in progress and its matching high phase keep their captured timing.
- R10: Dropping `en` while the generator is running returns `scl` to 1 at the next clock edge. If `scl` was low, that edge raises `scl_edge`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run the SCL generator |
| hs_sel | input | 1 | Request high-speed timing |
| nrm_word | input | 16 | Normal timing word: sample−1 at [10:8], step−1 at [5:0] |
| hs_word | input | 16 | High-speed word: sample−1 at [14:12], step−1 at [10:8], 3 in [1:0] when valid |
| div_word | input | 8 | Front divider minus one |
| sda_word | input | 16 | Data-change placement: enable at [12], offset at [5:0] |
| scl | output | 1 | SCL level |
| scl_edge | output | 1 | One-clock pulse on every SCL transition |
| data_stb | output | 1 | One-clock data-change strobe inside SCL low |

## Verification
The bench measures the low length, the high length and the strobe offset for single-cycle halves, for a 64-step normal phase, for the largest high-speed product and for a 256 front division. A counter that wraps one step early or late would show up as a half-period off by div × sample cycles. The bench also exercises an invalid high-speed word with `hs_sel` set and a valid one with `hs_sel` clear; a wrong mode decode would produce the other mode's period. An oversized offset must clamp to the last sample of low. Without the clamp, the strobe would go missing. A timing write made mid-phase must leave the running phase alone, so a design that reloads its timing immediately would cut that phase short.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;

    // field widths
    localparam int CFG_W    = 16;
    localparam int DIV_W    = 8;
    localparam int SMP_W    = 3;
    localparam int STP_W    = 6;
    localparam int HS_STP_W = 3;

    // field positions inside the timing words
    localparam int NRM_SMP_LSB = 8;
    localparam int NRM_STP_LSB = 0;
    localparam int HS_SMP_LSB  = 12;
    localparam int HS_STP_LSB  = 8;
    localparam int HS_VLD_LSB  = 0;
    localparam int SDA_EN_BIT  = 12;
    localparam int SDA_K_LSB   = 0;

    localparam logic [1:0] HS_VALID_CODE = 2'b11;

    // timing set captured for one SCL period
    typedef struct packed {
        logic [DIV_W-1:0] div_m1;
        logic [SMP_W-1:0] smp_m1;
        logic [STP_W-1:0] stp_m1;
        logic [STP_W-1:0] sda_k;
    } phase_cfg_t;

    function automatic logic [STP_W-1:0] clamp_k(
        input logic [STP_W-1:0] k,
        input logic [STP_W-1:0] lim
    );
        return (k > lim) ? lim : k;
    endfunction

endpackage

// File: rtl/scl_cfg_sel.sv
module scl_cfg_sel
    import scl_tgen_pkg::*;
(
    input  logic [CFG_W-1:0] nrm_word,
    input  logic [CFG_W-1:0] hs_word,
    input  logic             hs_sel,
    input  logic [DIV_W-1:0] div_word,
    input  logic [CFG_W-1:0] sda_word,
    output phase_cfg_t       cfg
);
    logic             hs_use;
    logic [STP_W-1:0] stp_sel;
    logic [STP_W-1:0] k_raw;

    always_comb begin
        hs_use = hs_sel && (hs_word[HS_VLD_LSB +: 2] == HS_VALID_CODE);
        cfg.div_m1 = div_word;
        if (hs_use) begin
            cfg.smp_m1 = hs_word[HS_SMP_LSB +: SMP_W];
            stp_sel    = {{(STP_W-HS_STP_W){1'b0}}, hs_word[HS_STP_LSB +: HS_STP_W]};
        end else begin
            cfg.smp_m1 = nrm_word[NRM_SMP_LSB +: SMP_W];
            stp_sel    = nrm_word[NRM_STP_LSB +: STP_W];
        end
        cfg.stp_m1 = stp_sel;
        k_raw      = sda_word[SDA_EN_BIT] ? sda_word[SDA_K_LSB +: STP_W] : '0;
        cfg.sda_k  = clamp_k(k_raw, stp_sel);
    end
endmodule

// File: rtl/scl_cnt_stage.sv
module scl_cnt_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         adv,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = adv && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             hs_sel,
    input  logic [CFG_W-1:0] nrm_word,
    input  logic [CFG_W-1:0] hs_word,
    input  logic [DIV_W-1:0] div_word,
    input  logic [CFG_W-1:0] sda_word,
    output logic             scl,
    output logic             scl_edge,
    output logic             data_stb
);
    phase_cfg_t       cfg_new;
    phase_cfg_t       cfg_q;
    logic             running;
    logic             tick_d;
    logic             tick_s;
    logic             tick_t;
    logic [DIV_W-1:0] dcnt;
    logic [SMP_W-1:0] scnt;
    logic [STP_W-1:0] tcnt;
    logic             k_hit;

    scl_cfg_sel u_sel (
        .nrm_word (nrm_word),
        .hs_word  (hs_word),
        .hs_sel   (hs_sel),
        .div_word (div_word),
        .sda_word (sda_word),
        .cfg      (cfg_new)
    );

    // front divider -> sample counter -> step counter
    scl_cnt_stage #(.W(DIV_W)) u_div (
        .clk (clk), .rst (rst), .run (running), .adv (1'b1),
        .lim (cfg_q.div_m1), .cnt (dcnt), .wrap (tick_d)
    );
    scl_cnt_stage #(.W(SMP_W)) u_smp (
        .clk (clk), .rst (rst), .run (running), .adv (tick_d),
        .lim (cfg_q.smp_m1), .cnt (scnt), .wrap (tick_s)
    );
    scl_cnt_stage #(.W(STP_W)) u_stp (
        .clk (clk), .rst (rst), .run (running), .adv (tick_s),
        .lim (cfg_q.stp_m1), .cnt (tcnt), .wrap (tick_t)
    );

    assign k_hit = tick_s && (({1'b0, tcnt} + 1'b1) == {1'b0, cfg_q.sda_k});

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            scl      <= 1'b1;
            scl_edge <= 1'b0;
            data_stb <= 1'b0;
            cfg_q    <= '0;
        end else begin
            scl_edge <= 1'b0;
            data_stb <= 1'b0;
            if (!running) begin
                if (en) begin
                    running  <= 1'b1;
                    scl      <= 1'b0;
                    scl_edge <= 1'b1;
                    cfg_q    <= cfg_new;
                    data_stb <= (cfg_new.sda_k == '0);
                end
            end else if (!en) begin
                running  <= 1'b0;
                scl      <= 1'b1;
                scl_edge <= !scl;
            end else if (tick_t) begin
                scl      <= !scl;
                scl_edge <= 1'b1;
                if (scl) begin
                    // new low phase: capture the timing set here only
                    cfg_q    <= cfg_new;
                    data_stb <= (cfg_new.sda_k == '0);
                end
            end else if (!scl && k_hit) begin
                data_stb <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic scl,
    input logic scl_edge,
    input logic data_stb
);
    // R6: every level change carries the edge strobe
    a_r6_edge_on_change: assert property (@(posedge clk) disable iff (rst)
        (scl != $past(scl)) |-> scl_edge);

    // R6: the edge strobe never appears without a level change
    a_r6_edge_only_on_change: assert property (@(posedge clk) disable iff (rst)
        scl_edge |-> (scl != $past(scl)));

    // R1, R10: with the enable low, SCL is high one edge later
    a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
        !en |=> scl);

    // R7, R8: data strobe sits inside the low phase
    a_r7_strobe_in_low: assert property (@(posedge clk) disable iff (rst)
        data_stb |-> !scl);

    // R2: enabling from idle pulls SCL low at once
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(en) && scl) |=> (!scl && scl_edge));
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .scl      (scl),
    .scl_edge (scl_edge),
    .data_stb (data_stb)
);

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [15:0] nrm;
        logic [15:0] hs;
        logic        sel;
        logic [7:0]  dv;
        logic [15:0] sda;
        int          n;     // expected half-period in cycles
        int          soff;  // expected strobe offset from fall
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{16'h0000, 16'h0000, 1'b0, 8'd0,   16'h0000, 1,   0},  // R3 minimum
        '{16'h0304, 16'h0000, 1'b0, 8'd0,   16'h1002, 20,  8},  // R3 R7
        '{16'h0102, 16'h0000, 1'b0, 8'd2,   16'h1001, 18,  6},  // R4 R7
        '{16'h0705, 16'h2303, 1'b1, 8'd0,   16'h1003, 12,  9},  // R5 hs used
        '{16'h0007, 16'h0000, 1'b1, 8'd0,   16'h0005, 8,   0},  // R5 hs zero, R7 disabled
        '{16'h0002, 16'h0000, 1'b0, 8'd0,   16'h103F, 3,   2},  // R8 clamp
        '{16'h003F, 16'h0000, 1'b0, 8'd0,   16'h0000, 64,  0},  // R3 max step
        '{16'h0000, 16'h7703, 1'b1, 8'd0,   16'h1007, 64,  56}, // R5 hs max
        '{16'h0000, 16'h0000, 1'b0, 8'd255, 16'h0000, 256, 0},  // R4 max div
        '{16'h0001, 16'h2303, 1'b0, 8'd0,   16'h1001, 2,   1}   // R5 not selected
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        hs_sel;
    logic [15:0] nrm_word;
    logic [15:0] hs_word;
    logic [7:0]  div_word;
    logic [15:0] sda_word;
    logic        scl;
    logic        scl_edge;
    logic        data_stb;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_timing_gen u0 (
        .clk (clk), .rst (rst), .en (en), .hs_sel (hs_sel),
        .nrm_word (nrm_word), .hs_word (hs_word), .div_word (div_word),
        .sda_word (sda_word), .scl (scl), .scl_edge (scl_edge),
        .data_stb (data_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // measures one low phase and the following high phase from the fall
    task automatic measure(input int chg_at, input logic [15:0] chg_nrm,
                           output int lo, output int hi, output int soff,
                           output int edges);
        lo = 0; hi = 0; soff = -1; edges = 0;
        while (scl && hi < 2000) begin hi++; @(negedge clk); end
        hi = 0;
        while (!scl && lo < 2000) begin
            if (data_stb && soff < 0) soff = lo;
            if (scl_edge) edges++;
            if (lo == chg_at) nrm_word = chg_nrm;
            lo++;
            @(negedge clk);
        end
        while (scl && hi < 2000) begin
            if (scl_edge) edges++;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic stop_run();
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lo, hi, so, ed;
        rst = 1'b1; en = 1'b0; hs_sel = 1'b0;
        nrm_word = '0; hs_word = '0; div_word = '0; sda_word = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 scl in reset", int'(scl), 1);
        chk("R1 edge in reset", int'(scl_edge), 0);
        chk("R1 strobe in reset", int'(data_stb), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 idle scl", int'(scl), 1);
        chk("R1 idle edge", int'(scl_edge), 0);

        // table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            nrm_word = VT[i].nrm; hs_word = VT[i].hs; hs_sel = VT[i].sel;
            div_word = VT[i].dv;  sda_word = VT[i].sda;
            en = 1'b1;
            @(negedge clk);
            // R2: low with edge one edge after enable
            chk("R2 start low", int'(scl), 0);
            chk("R2 start edge", int'(scl_edge), 1);
            measure(-1, 16'h0, lo, hi, so, ed);
            chk("R3 low length", lo, VT[i].n);
            chk("R3 high length", hi, VT[i].n);
            chk("R7 strobe offset", so, VT[i].soff);
            chk("R6 edge count", ed, 2);
            stop_run();
        end

        // R9: mid-phase change must not touch the running period
        nrm_word = 16'h0304; hs_word = '0; hs_sel = 1'b0;
        div_word = '0; sda_word = '0;
        en = 1'b1;
        @(negedge clk);
        measure(5, 16'h0002, lo, hi, so, ed);
        chk("R9 current low kept", lo, 20);
        chk("R9 current high kept", hi, 20);
        measure(-1, 16'h0, lo, hi, so, ed);
        chk("R9 next low new", lo, 3);
        chk("R9 next high new", hi, 3);

        // R10: dropping enable mid-low
        repeat (1) @(negedge clk);
        chk("R10 low before stop", int'(scl), 0);
        en = 1'b0;
        @(negedge clk);
        chk("R10 scl high", int'(scl), 1);
        chk("R10 edge on stop", int'(scl_edge), 1);
        @(negedge clk);
        chk("R10 edge single", int'(scl_edge), 0);
        chk("R1 stays high", int'(scl), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule